// File: doc/BRIEF.md
# Trapezoidal Ringing Waveform Generator

This block produces the digital drive for a telephone ringing signal: one signed 16-bit sample each time the sample strobe (nominally 8 kHz) is taken. In trapezoid mode a running value climbs or falls by a programmable step on every sample. It clamps at plus or minus a programmable peak and stays flat there. Its direction flips each time a half-period counter runs out. In sinusoid mode an externally generated sinusoid sample passes through instead. In both modes a signed dc offset can be added, and the sum saturates to the signed 16-bit range.

Settings are loaded through a plain write port: half-period count, peak magnitude, ramp step, offset and a control word. Writes to the half-period, peak and step land in staging registers and take effect at the next half-period boundary, so a cycle already in progress is never distorted. The control word and the offset take effect at once. Samples leave on a valid/ready stream. A strobe is taken only when the output register is empty or is being drained in the same cycle. A strobe that arrives while the consumer holds off is dropped, and the generator does not advance. An accepted sample stays on `out_data` until it is consumed.

Top module: `trap_ring_gen`

## Requirements
- R1: A synchronous reset clears `out_valid`, sets the running value to 0 and the direction to rising, loads the half-period counter with 200, and clears peak, step, offset and control. After reset the half-period staging value is 200.
- R2: A strobe is accepted only when `out_valid` is 0 or `out_ready` is 1. An accepted strobe makes `out_valid` 1 on the next cycle with the new sample. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. A dropped strobe changes no state.
- R3: In trapezoid mode each accepted strobe adds the step to the running value (rising) or subtracts it (falling). The result is clamped to +peak or −peak, and that result is the sample.
- R4: The direction inverts after every N accepted trapezoid strobes, where N is the half-period value (address 0). The counter reloads from the staged value at each boundary, and a staged value of 0 acts as 1.
- R5: Peak (address 1, bits 14:0) and step (address 2, bits 14:0) become active only at the half-period boundary after the write. The boundary sample still uses the old values.
- R6: Control bit 1 (address 4) enables the signed offset (address 3), which is added to every sample from the next strobe on.
- R7: The sum of source and offset saturates to +32767 / −32768 instead of wrapping.
- R8: Control bit 0 (address 4) selects the source: 0 passes `sin_sample`, 1 selects the trapezoid. While the sinusoid is selected, the generator's value, direction and counter hold.
- R9: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| sample_tick | input | 1 | Sample strobe |
| sin_sample | input | 16 | Signed external sinusoid sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 16 | Signed output sample |

## Verification
The bench sets the half-period short enough that samples land exactly on the clamp and that clamping and reversal coincide. A wrong clamp overshoots the peak, and an off-by-one counter makes one flat side longer than the other. It changes peak and step in the middle of a half period and expects the boundary sample to still use the old values; a design that loads immediately shows a slope break mid-cycle. It stalls the consumer while strobes keep coming, which catches a design that advances on dropped strobes or overwrites a held sample. It also drives offset plus sinusoid past both rails, where a wrapping adder flips sign, and switches modes back and forth to show the trapezoid resumes where it stopped.

// File: rtl/trap_ring_pkg.sv
package trap_ring_pkg;
  typedef enum logic [2:0] {
    CFG_HALF = 3'd0,
    CFG_AMP  = 3'd1,
    CFG_STEP = 3'd2,
    CFG_OFS  = 3'd3,
    CFG_CTRL = 3'd4
  } cfg_addr_e;

  localparam int CTRL_SHAPE_BIT = 0;
  localparam int CTRL_OFS_BIT   = 1;
endpackage

// File: rtl/trap_cfg_regs.sv
module trap_cfg_regs
  import trap_ring_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int RST_HALF = 200,
  localparam int MAG_W   = DATA_W - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [2:0]               addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     load,
  output logic [CNT_W-1:0]         reload_half,
  output logic [MAG_W-1:0]         act_amp,
  output logic [MAG_W-1:0]         act_step,
  output logic signed [DATA_W-1:0] offset,
  output logic                     shape_sel,
  output logic                     ofs_en
);
  logic [CNT_W-1:0] stg_half;
  logic [MAG_W-1:0] stg_amp;
  logic [MAG_W-1:0] stg_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_half  <= CNT_W'(RST_HALF);
      stg_amp   <= '0;
      stg_step  <= '0;
      act_amp   <= '0;
      act_step  <= '0;
      offset    <= '0;
      shape_sel <= 1'b0;
      ofs_en    <= 1'b0;
    end else begin
      if (load) begin
        act_amp  <= stg_amp;
        act_step <= stg_step;
      end
      if (we) begin
        case (addr)
          CFG_HALF: stg_half <= CNT_W'(wdata);
          CFG_AMP:  stg_amp  <= wdata[MAG_W-1:0];
          CFG_STEP: stg_step <= wdata[MAG_W-1:0];
          CFG_OFS:  offset   <= wdata;
          CFG_CTRL: begin
            shape_sel <= wdata[CTRL_SHAPE_BIT];
            ofs_en    <= wdata[CTRL_OFS_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  assign reload_half = (stg_half == '0) ? CNT_W'(1) : stg_half;

  // R5: active shape settings move only on a boundary
  assert_shape_latched_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_amp) && $stable(act_step)));
endmodule

// File: rtl/trap_ramp_core.sv
module trap_ramp_core #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int RST_HALF = 200,
  localparam int MAG_W   = DATA_W - 1,
  localparam int SUM_W   = DATA_W + 2,
  localparam int RST_CNT = (RST_HALF == 0) ? 1 : RST_HALF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic [MAG_W-1:0]       amp,
  input  logic [MAG_W-1:0]       step,
  input  logic [CNT_W-1:0]       reload_half,
  output logic signed [DATA_W:0] wave_next,
  output logic                   boundary
);
  logic signed [DATA_W:0] val;
  logic                   rising;
  logic [CNT_W-1:0]       cnt;

  logic signed [SUM_W-1:0] amp_s, step_s, val_s, trial, clamped;

  always_comb begin
    amp_s  = $signed({{(SUM_W-MAG_W){1'b0}}, amp});
    step_s = $signed({{(SUM_W-MAG_W){1'b0}}, step});
    val_s  = {{(SUM_W-DATA_W-1){val[DATA_W]}}, val};
    trial  = rising ? (val_s + step_s) : (val_s - step_s);
    clamped = trial;
    if (rising && (trial > amp_s))
      clamped = amp_s;
    else if (!rising && (trial < -amp_s))
      clamped = -amp_s;
    wave_next = clamped[DATA_W:0];
  end

  assign boundary = adv && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      val    <= '0;
      rising <= 1'b1;
      cnt    <= CNT_W'(RST_CNT);
    end else if (adv) begin
      val <= wave_next;
      if (boundary) begin
        rising <= ~rising;
        cnt    <= reload_half;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R8: generator frozen while not advanced
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(val) && $stable(rising) && $stable(cnt)));
  // R4: counter never parks at zero
  assert_cnt_live_R4: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);
  // R4: every boundary flips direction
  assert_flip_R4: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (rising != $past(rising)));
endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
  parameter int DATA_W = 16,
  localparam int SUM_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     out_ready,
  input  logic                     shape_sel,
  input  logic                     ofs_en,
  input  logic signed [DATA_W-1:0] offset,
  input  logic signed [DATA_W:0]   wave_next,
  input  logic signed [DATA_W-1:0] sin_sample,
  output logic                     accept,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);

  logic signed [SUM_W-1:0] src, ofs_x, sum, sat;

  assign accept = tick && (!out_valid || out_ready);

  always_comb begin
    src = shape_sel ? {{(SUM_W-DATA_W-1){wave_next[DATA_W]}}, wave_next}
                    : {{(SUM_W-DATA_W){sin_sample[DATA_W-1]}}, sin_sample};
    ofs_x = ofs_en ? {{(SUM_W-DATA_W){offset[DATA_W-1]}}, offset} : '0;
    sum = src + ofs_x;
    if (sum > MAX_S)      sat = MAX_S;
    else if (sum < MIN_S) sat = MIN_S;
    else                  sat = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= sat[DATA_W-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a held sample stays put
  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R2: taken strobe yields a sample
  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
endmodule

// File: rtl/trap_ring_gen.sv
module trap_ring_gen #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int RST_HALF = 200,
  localparam int MAG_W   = DATA_W - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     sample_tick,
  input  logic signed [DATA_W-1:0] sin_sample,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  logic                   boundary, accept, adv, shape_sel, ofs_en;
  logic [CNT_W-1:0]       reload_half;
  logic [MAG_W-1:0]       act_amp, act_step;
  logic signed [DATA_W-1:0] offset;
  logic signed [DATA_W:0]   wave_next;

  assign adv = accept && shape_sel;

  trap_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_HALF(RST_HALF)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(boundary), .reload_half(reload_half), .act_amp(act_amp),
    .act_step(act_step), .offset(offset), .shape_sel(shape_sel), .ofs_en(ofs_en)
  );

  trap_ramp_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_HALF(RST_HALF)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .amp(act_amp), .step(act_step),
    .reload_half(reload_half), .wave_next(wave_next), .boundary(boundary)
  );

  trap_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .tick(sample_tick), .out_ready(out_ready),
    .shape_sel(shape_sel), .ofs_en(ofs_en), .offset(offset),
    .wave_next(wave_next), .sin_sample(sin_sample), .accept(accept),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/trap_ring_gen_bench.sv
`timescale 1ns/1ps
module trap_ring_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic sample_tick = 1'b0;
  logic signed [15:0] sin_sample = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_val, m_cnt, s_half, s_amp, s_step, a_amp, a_step, m_ofs, m_md;
  bit m_up, m_sel, m_oen, m_mv;

  always #2 clk = ~clk;

  trap_ring_gen u_trap_ring_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sample_tick(sample_tick), .sin_sample(sin_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    m_val = 0; m_up = 1; m_cnt = 200; s_half = 200; s_amp = 0; s_step = 0;
    a_amp = 0; a_step = 0; m_ofs = 0; m_sel = 0; m_oen = 0; m_mv = 0; m_md = 0;
  endtask

  task automatic model_edge(bit we, int addr, int data, bit tick, bit rdy, int sin);
    int src;
    if (tick && (!m_mv || rdy)) begin
      if (m_sel) begin
        if (m_up) src = (m_val + a_step > a_amp) ? a_amp : m_val + a_step;
        else      src = (m_val - a_step < -a_amp) ? -a_amp : m_val - a_step;
        m_val = src;
        if (m_cnt == 1) begin
          m_up = !m_up;
          m_cnt = (s_half == 0) ? 1 : s_half;
          a_amp = s_amp; a_step = s_step;
        end else m_cnt = m_cnt - 1;
      end else src = sin;
      m_mv = 1;
      m_md = sat16(src + (m_oen ? m_ofs : 0));
    end else if (rdy) m_mv = 0;
    if (we) begin
      case (addr)
        0: s_half = data & 16'hFFFF;
        1: s_amp  = data & 16'h7FFF;
        2: s_step = data & 16'h7FFF;
        3: m_ofs  = int'($signed(16'(data)));
        4: begin m_sel = data[0]; m_oen = data[1]; end
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (out_valid !== m_mv) begin
      errors++;
      $display("FAIL %s out_valid actual %0b expected %0b", tag, out_valid, m_mv);
    end else if (m_mv && (int'(out_data) != m_md)) begin
      errors++;
      $display("FAIL %s out_data actual %0d expected %0d", tag, out_data, m_md);
    end
  endtask

  task automatic cyc(bit we, int addr, int data, bit tick, bit rdy, int sin, string tag);
    cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    sample_tick = tick; out_ready = rdy; sin_sample = 16'(sin);
    model_edge(we, addr, data, tick, rdy, sin);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(int addr, int data, string tag);
    cyc(1, addr, data, 0, 1, 0, tag);
  endtask

  // stall_mod: ready low when i % stall_mod == 0 (0 = never stall)
  task automatic run(int n, int stall_mod, int sin_base, string tag);
    for (int i = 0; i < n; i++)
      cyc(0, 0, 0, 1, (stall_mod == 0) ? 1'b1 : ((i % stall_mod) != 0),
          sin_base + (i % 7) * 300, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_valid in reset actual %0b expected 0", out_valid);
    end
    rst = 1'b0;
    cyc(0, 0, 0, 0, 1, 0, "R1");
    // R1/R5: reset half of 200 runs with zero peak before staged shape lands
    wr(0, 6, "R5"); wr(1, 1000, "R5"); wr(2, 300, "R5"); wr(4, 1, "R8");
    run(205, 0, 0, "R5");
    // R3/R4: ramp, clamp and reversal
    run(40, 0, 0, "R3");
    // R2: back-pressure with strobes every cycle
    run(45, 3, 0, "R2");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, i[0], i[1], 0, "R2");
    // R6: offset enabled
    wr(3, -200, "R6"); wr(4, 3, "R6");
    run(20, 0, 0, "R6");
    // R5: mid-cycle change of peak and step
    run(2, 0, 0, "R5");
    wr(1, 2000, "R5"); wr(2, 700, "R5"); wr(0, 5, "R5");
    run(30, 0, 0, "R5");
    // R8/R7: sinusoid pass-through with offset saturation
    wr(4, 2, "R8");
    run(10, 0, -1000, "R8");
    wr(3, 30000, "R7");
    run(10, 0, 1000, "R7");
    wr(3, -30000, "R7");
    run(10, 0, -4000, "R7");
    // R8: generator resumes where it stopped
    wr(3, 0, "R8"); wr(4, 1, "R8");
    run(15, 0, 0, "R8");
    // R7: trapezoid at full peak plus offset
    wr(1, 32767, "R7"); wr(2, 20000, "R7"); wr(3, 3000, "R7"); wr(4, 3, "R7");
    run(30, 0, 0, "R7");
    // R4: zero half-period behaves as one
    wr(0, 0, "R4");
    run(20, 0, 0, "R4");
    // R9: unused addresses
    wr(5, 16'hFFFF, "R9"); wr(6, 16'h1234, "R9"); wr(7, 0, "R9");
    run(20, 4, 0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule